// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits on the upstream side of a PCI-to-PCI style bridge and decides, for each request address, whether the bridge should claim the transaction and pass it downstream. It rebuilds three forwarding windows from the raw contents of the bridge's base and limit registers. The three windows are I/O, non-prefetchable memory and prefetchable memory. It also recognises the fixed legacy VGA ranges when the bridge's VGA forwarding control is on.

Each window is formed from packed register fields. The significant address bits come from the upper part of each register. Optional upper-half registers widen the window when a type code asks for it. The limit's low bits are forced to ones, which sets the window granularity. A space flag says whether the request is I/O or memory. The command-register enables gate each window. The decision is computed combinationally and registered once, so results appear one clock after the inputs.

Top module: `bridge_window_decoder`

## Requirements
- R1: While `rst_n` is low, `claim` and `hit_vec` are zero.
- R2: I/O window: base = `io_base_up`×65536 (only when `io_base_reg[3:0]` = 1, else 0) + `io_base_reg[7:4]`×4096. The limit is built the same way from `io_limit_reg` and `io_limit_up`, plus 4095. Only `req_addr[31:0]` is compared for I/O requests.
- R3: Memory window: base = `mem_base_reg[15:4]`×2^20 and limit = `mem_limit_reg[15:4]`×2^20 + 2^20−1, compared against the full 64-bit address. An address at or above 4 GiB never hits it.
- R4: Prefetchable window: base and limit follow R3 from `pf_base_reg`/`pf_limit_reg`. When that register's bits [3:0] = 1, `pf_base_up`/`pf_limit_up` add ×2^32.
- R5: A hit needs base ≤ address ≤ limit, both bounds inclusive. A window whose limit is below its base never hits.
- R6: The I/O window and the VGA I/O ranges hit only when `cmd_io_en` = 1. The memory, prefetchable and VGA memory ranges hit only when `cmd_mem_en` = 1.
- R7: I/O-space hits occur only when `req_is_io` = 1 and memory-space hits only when `req_is_io` = 0. Bits 63:32 of `req_addr` have no effect on I/O requests.
- R8: With `vga_en` = 1, the VGA hit is set for memory 0xA0000–0xBFFFF and for I/O 0x3B0–0x3BB and 0x3C0–0x3DF. With `vga_en` = 0 it is never set.
- R9: `hit_vec` bit 0 = I/O, bit 1 = memory, bit 2 = prefetchable, bit 3 = VGA. `claim` is the OR of the four bits.
- R10: Outputs reflect the inputs present at the previous rising clock edge (one cycle latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_io_en | input | 1 | Command I/O space enable |
| cmd_mem_en | input | 1 | Command memory space enable |
| vga_en | input | 1 | Legacy VGA forwarding control |
| io_base_reg | input | 8 | I/O base register (bits 7:4 address, 3:0 type) |
| io_limit_reg | input | 8 | I/O limit register |
| io_base_up | input | 16 | I/O base upper half (address 31:16) |
| io_limit_up | input | 16 | I/O limit upper half |
| mem_base_reg | input | 16 | Memory base register (bits 15:4 address) |
| mem_limit_reg | input | 16 | Memory limit register |
| pf_base_reg | input | 16 | Prefetchable base register (15:4 address, 3:0 type) |
| pf_limit_reg | input | 16 | Prefetchable limit register |
| pf_base_up | input | 32 | Prefetchable base upper word (address 63:32) |
| pf_limit_up | input | 32 | Prefetchable limit upper word |
| req_addr | input | 64 | Request address |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| claim | output | 1 | Registered forward/claim decision |
| hit_vec | output | 4 | Registered per-window hit vector |

## Verification
The assertions assume that the register fields, the enables and the space flag stay constant between clock edges. They also assume that reset is only released after the first edge. The bench meets both assumptions by changing inputs only on falling edges and holding them for a full cycle before it samples. The gating and empty-window properties rely on the inputs being treated as static register contents. The sweeps pick register values arithmetically and probe each window one below its base, at its base, at its limit and one above its limit. As a result, the boundary addresses always come from the same register values the design sees.

// File: rtl/bawd_pkg.sv
package bawd_pkg;
    localparam int IO_AW    = 32;
    localparam int MEM_AW   = 64;
    localparam int NWIN     = 4;
    localparam int IDX_IO   = 0;
    localparam int IDX_MEM  = 1;
    localparam int IDX_PREF = 2;
    localparam int IDX_VGA  = 3;
    localparam int NRANGE   = 3;

    localparam logic [3:0] IO_TYPE_WIDE = 4'h1;
    localparam logic [3:0] PF_TYPE_WIDE = 4'h1;

    localparam logic [MEM_AW-1:0] VGA_MEM_LO = 64'h0000_0000_000A_0000;
    localparam logic [MEM_AW-1:0] VGA_MEM_HI = 64'h0000_0000_000B_FFFF;
    localparam logic [IO_AW-1:0]  VGA_IOA_LO = 32'h0000_03B0;
    localparam logic [IO_AW-1:0]  VGA_IOA_HI = 32'h0000_03BB;
    localparam logic [IO_AW-1:0]  VGA_IOB_LO = 32'h0000_03C0;
    localparam logic [IO_AW-1:0]  VGA_IOB_HI = 32'h0000_03DF;
endpackage

// File: rtl/bawd_range_cmp.sv
module bawd_range_cmp #(
    parameter int AW = 64
) (
    input  logic          en,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    always_comb begin
        hit = en && (addr >= lo) && (addr <= hi);
    end
endmodule

// File: rtl/bawd_io_window.sv
module bawd_io_window
    import bawd_pkg::*;
(
    input  logic [7:0]       base_reg,
    input  logic [7:0]       limit_reg,
    input  logic [15:0]      base_up,
    input  logic [15:0]      limit_up,
    output logic [IO_AW-1:0] lo,
    output logic [IO_AW-1:0] hi
);
    function automatic logic [IO_AW-1:0] form_io(input logic [7:0] r,
                                                 input logic [15:0] up,
                                                 input logic pad);
        logic [IO_AW-1:0] v;
        v = '0;
        v[15:12] = r[7:4];
        if (r[3:0] == IO_TYPE_WIDE) begin
            v[31:16] = up;
        end
        if (pad) begin
            v[11:0] = '1;
        end
        return v;
    endfunction

    always_comb begin
        lo = form_io(base_reg, base_up, 1'b0);
        hi = form_io(limit_reg, limit_up, 1'b1);
    end
endmodule

// File: rtl/bawd_mem_window.sv
module bawd_mem_window
    import bawd_pkg::*;
#(
    parameter bit WIDE = 1'b0
) (
    input  logic [15:0]       base_reg,
    input  logic [15:0]       limit_reg,
    input  logic [31:0]       base_up,
    input  logic [31:0]       limit_up,
    output logic [MEM_AW-1:0] lo,
    output logic [MEM_AW-1:0] hi
);
    logic [MEM_AW-1:0] lo_low;
    logic [MEM_AW-1:0] hi_low;

    always_comb begin
        lo_low = '0;
        hi_low = '0;
        lo_low[31:20] = base_reg[15:4];
        hi_low[31:20] = limit_reg[15:4];
        hi_low[19:0]  = '1;
    end

    generate
        if (WIDE) begin : g_wide
            always_comb begin
                lo = lo_low;
                hi = hi_low;
                if (base_reg[3:0] == PF_TYPE_WIDE) begin
                    lo[63:32] = base_up;
                end
                if (limit_reg[3:0] == PF_TYPE_WIDE) begin
                    hi[63:32] = limit_up;
                end
            end
        end else begin : g_narrow
            logic unused_up;
            assign unused_up = ^{base_up, limit_up, base_reg[3:0], limit_reg[3:0]};
            always_comb begin
                lo = lo_low;
                hi = hi_low;
            end
        end
    endgenerate
endmodule

// File: rtl/bawd_vga_match.sv
module bawd_vga_match
    import bawd_pkg::*;
(
    input  logic              vga_en,
    input  logic              io_ok,
    input  logic              mem_ok,
    input  logic [MEM_AW-1:0] addr,
    output logic              hit
);
    logic [IO_AW-1:0] io_addr;
    logic             io_a;
    logic             io_b;
    logic             mem_r;

    always_comb begin
        io_addr = addr[IO_AW-1:0];
        io_a    = (io_addr >= VGA_IOA_LO) && (io_addr <= VGA_IOA_HI);
        io_b    = (io_addr >= VGA_IOB_LO) && (io_addr <= VGA_IOB_HI);
        mem_r   = (addr >= VGA_MEM_LO) && (addr <= VGA_MEM_HI);
        hit     = vga_en && ((io_ok && (io_a || io_b)) || (mem_ok && mem_r));
    end
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
    import bawd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_io_en,
    input  logic              cmd_mem_en,
    input  logic              vga_en,
    input  logic [7:0]        io_base_reg,
    input  logic [7:0]        io_limit_reg,
    input  logic [15:0]       io_base_up,
    input  logic [15:0]       io_limit_up,
    input  logic [15:0]       mem_base_reg,
    input  logic [15:0]       mem_limit_reg,
    input  logic [15:0]       pf_base_reg,
    input  logic [15:0]       pf_limit_reg,
    input  logic [31:0]       pf_base_up,
    input  logic [31:0]       pf_limit_up,
    input  logic [MEM_AW-1:0] req_addr,
    input  logic              req_is_io,
    output logic              claim,
    output logic [NWIN-1:0]   hit_vec
);
    logic [IO_AW-1:0]  io_lo;
    logic [IO_AW-1:0]  io_hi;
    logic [MEM_AW-1:0] win_lo   [NRANGE];
    logic [MEM_AW-1:0] win_hi   [NRANGE];
    logic [MEM_AW-1:0] win_addr [NRANGE];
    logic              win_en   [NRANGE];
    logic [NWIN-1:0]   hit_d;
    logic              io_ok;
    logic              mem_ok;

    assign io_ok  = cmd_io_en & req_is_io;
    assign mem_ok = cmd_mem_en & ~req_is_io;

    bawd_io_window i_io_win (
        .base_reg  (io_base_reg),
        .limit_reg (io_limit_reg),
        .base_up   (io_base_up),
        .limit_up  (io_limit_up),
        .lo        (io_lo),
        .hi        (io_hi)
    );

    bawd_mem_window #(.WIDE(1'b0)) i_mem_win (
        .base_reg  (mem_base_reg),
        .limit_reg (mem_limit_reg),
        .base_up   (32'h0),
        .limit_up  (32'h0),
        .lo        (win_lo[IDX_MEM]),
        .hi        (win_hi[IDX_MEM])
    );

    bawd_mem_window #(.WIDE(1'b1)) i_pf_win (
        .base_reg  (pf_base_reg),
        .limit_reg (pf_limit_reg),
        .base_up   (pf_base_up),
        .limit_up  (pf_limit_up),
        .lo        (win_lo[IDX_PREF]),
        .hi        (win_hi[IDX_PREF])
    );

    always_comb begin
        win_lo[IDX_IO]     = {{(MEM_AW-IO_AW){1'b0}}, io_lo};
        win_hi[IDX_IO]     = {{(MEM_AW-IO_AW){1'b0}}, io_hi};
        win_addr[IDX_IO]   = {{(MEM_AW-IO_AW){1'b0}}, req_addr[IO_AW-1:0]};
        win_addr[IDX_MEM]  = req_addr;
        win_addr[IDX_PREF] = req_addr;
        win_en[IDX_IO]     = io_ok;
        win_en[IDX_MEM]    = mem_ok;
        win_en[IDX_PREF]   = mem_ok;
    end

    generate
        for (genvar w = 0; w < NRANGE; w++) begin : g_cmp
            bawd_range_cmp #(.AW(MEM_AW)) i_cmp (
                .en   (win_en[w]),
                .lo   (win_lo[w]),
                .hi   (win_hi[w]),
                .addr (win_addr[w]),
                .hit  (hit_d[w])
            );
        end
    endgenerate

    bawd_vga_match i_vga (
        .vga_en (vga_en),
        .io_ok  (io_ok),
        .mem_ok (mem_ok),
        .addr   (req_addr),
        .hit    (hit_d[IDX_VGA])
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_vec <= '0;
            claim   <= 1'b0;
        end else begin
            hit_vec <= hit_d;
            claim   <= |hit_d;
        end
    end
endmodule

// File: rtl/bawd_checker.sv
module bawd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_io_en,
    input logic       cmd_mem_en,
    input logic       vga_en,
    input logic       req_is_io,
    input logic [7:0] io_base_reg,
    input logic [7:0] io_limit_reg,
    input logic       claim,
    input logic [3:0] hit_vec
);
    AST_CLAIM_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        claim == (hit_vec != 4'h0)); // R9

    AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_io_en |=> !hit_vec[0]); // R6

    AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_mem_en |=> (!hit_vec[1] && !hit_vec[2])); // R6

    AST_SPACE_IO: assert property (@(posedge clk) disable iff (!rst_n)
        req_is_io |=> (!hit_vec[1] && !hit_vec[2])); // R7

    AST_SPACE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !req_is_io |=> !hit_vec[0]); // R7

    AST_VGA_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !vga_en |=> !hit_vec[3]); // R8

    AST_IO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (io_base_reg[3:0] != 4'h1 && io_limit_reg[3:0] != 4'h1 &&
         io_limit_reg[7:4] < io_base_reg[7:4]) |=> !hit_vec[0]); // R5
endmodule

bind bridge_window_decoder bawd_checker i_bawd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_io_en    (cmd_io_en),
    .cmd_mem_en   (cmd_mem_en),
    .vga_en       (vga_en),
    .req_is_io    (req_is_io),
    .io_base_reg  (io_base_reg),
    .io_limit_reg (io_limit_reg),
    .claim        (claim),
    .hit_vec      (hit_vec)
);

// File: tb/test_bridge_window_decoder.sv
`timescale 1ns/1ps
module test_bridge_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_io_en, cmd_mem_en, vga_en, req_is_io;
    logic [7:0]  io_base_reg, io_limit_reg;
    logic [15:0] io_base_up, io_limit_up;
    logic [15:0] mem_base_reg, mem_limit_reg, pf_base_reg, pf_limit_reg;
    logic [31:0] pf_base_up, pf_limit_up;
    logic [63:0] req_addr;
    logic        claim;
    logic [3:0]  hit_vec;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bridge_window_decoder i_bridge_window_decoder (
        .clk(clk), .rst_n(rst_n), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
        .vga_en(vga_en), .io_base_reg(io_base_reg), .io_limit_reg(io_limit_reg),
        .io_base_up(io_base_up), .io_limit_up(io_limit_up),
        .mem_base_reg(mem_base_reg), .mem_limit_reg(mem_limit_reg),
        .pf_base_reg(pf_base_reg), .pf_limit_reg(pf_limit_reg),
        .pf_base_up(pf_base_up), .pf_limit_up(pf_limit_up),
        .req_addr(req_addr), .req_is_io(req_is_io), .claim(claim), .hit_vec(hit_vec)
    );

    function automatic logic [3:0] ref_hits();
        logic [64:0] a, a32, lo, hi;
        logic [3:0]  r;
        r   = 4'h0;
        a   = {1'b0, req_addr};
        a32 = a % 65'h1_0000_0000;
        lo = io_base_reg[7:4] * 65'd4096;
        hi = io_limit_reg[7:4] * 65'd4096 + 65'd4095;
        if (io_base_reg[3:0] == 4'h1)  lo = lo + io_base_up * 65'd65536;
        if (io_limit_reg[3:0] == 4'h1) hi = hi + io_limit_up * 65'd65536;
        if (req_is_io && cmd_io_en && a32 >= lo && a32 <= hi) r[0] = 1'b1;
        lo = mem_base_reg[15:4] * 65'h10_0000;
        hi = mem_limit_reg[15:4] * 65'h10_0000 + 65'hF_FFFF;
        if (!req_is_io && cmd_mem_en && a >= lo && a <= hi) r[1] = 1'b1;
        lo = pf_base_reg[15:4] * 65'h10_0000;
        hi = pf_limit_reg[15:4] * 65'h10_0000 + 65'hF_FFFF;
        if (pf_base_reg[3:0] == 4'h1)  lo = lo + pf_base_up * 65'h1_0000_0000;
        if (pf_limit_reg[3:0] == 4'h1) hi = hi + pf_limit_up * 65'h1_0000_0000;
        if (!req_is_io && cmd_mem_en && a >= lo && a <= hi) r[2] = 1'b1;
        if (vga_en) begin
            if (req_is_io && cmd_io_en &&
                ((a32 >= 65'h3B0 && a32 <= 65'h3BB) || (a32 >= 65'h3C0 && a32 <= 65'h3DF)))
                r[3] = 1'b1;
            if (!req_is_io && cmd_mem_en && a >= 65'hA0000 && a <= 65'hBFFFF)
                r[3] = 1'b1;
        end
        return r;
    endfunction

    // Inputs are set at a falling edge; result sampled one falling edge later (R10).
    task automatic check_now(input string req);
        logic [3:0] e;
        e = ref_hits();
        @(negedge clk);
        checks++;
        if (hit_vec !== e || claim !== (e != 4'h0)) begin
            errors++;
            $display("FAIL %s addr=%h io=%0b: hit_vec=%b claim=%b expected hit_vec=%b claim=%b",
                     req, req_addr, req_is_io, hit_vec, claim, e, (e != 4'h0));
        end
    endtask

    task automatic probe4(input string req, input logic [64:0] lo, input logic [64:0] hi,
                          input logic [63:0] or_bits);
        logic [64:0] pts [4];
        pts[0] = lo - 65'd1; pts[1] = lo; pts[2] = hi; pts[3] = hi + 65'd1;
        for (int k = 0; k < 4; k++) begin
            req_addr = pts[k][63:0] | or_bits;
            check_now(req);
        end
    endtask

    task automatic all_empty();
        io_base_reg = 8'hF0; io_limit_reg = 8'h00; io_base_up = 16'h0; io_limit_up = 16'h0;
        mem_base_reg = 16'hFFF0; mem_limit_reg = 16'h0000;
        pf_base_reg = 16'hFFF0; pf_limit_reg = 16'h0000;
        pf_base_up = 32'h0; pf_limit_up = 32'h0;
        vga_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: expired, expected the run to complete");
            finish_run();
        end
    end

    initial begin
        logic [64:0] lo, hi;
        // R1: reset holds outputs low even with a hitting request
        all_empty();
        cmd_io_en = 1'b1; cmd_mem_en = 1'b1; req_is_io = 1'b0;
        mem_base_reg = 16'h0000; mem_limit_reg = 16'hFFF0; req_addr = 64'h1000;
        repeat (3) @(negedge clk);
        checks++;
        if (claim !== 1'b0 || hit_vec !== 4'h0) begin
            errors++;
            $display("FAIL R1: claim=%b hit_vec=%b expected 0 0000", claim, hit_vec);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check_now("R10 first decode after reset");

        // R2 R5 R7: I/O sweep, 16-bit and 32-bit forms, upper address bits set
        all_empty(); req_is_io = 1'b1; cmd_io_en = 1'b1;
        for (int b = 0; b < 16; b++) begin
            for (int l = 0; l < 16; l++) begin
                logic wide;
                wide = ((b + l) % 3 == 0);
                io_base_reg  = {b[3:0], wide ? 4'h1 : 4'h0};
                io_limit_reg = {l[3:0], wide ? 4'h1 : 4'h0};
                io_base_up   = 16'(b * 3);
                io_limit_up  = 16'(l * 3);
                lo = b * 4096 + (wide ? b * 3 * 65536 : 0);
                hi = l * 4096 + 4095 + (wide ? l * 3 * 65536 : 0);
                probe4("R2/R5/R7 io window", lo, hi, 64'hA5A5_0000_0000_0000);
            end
        end

        // R3 R5: memory window sweep, plus above-4GiB aliases
        all_empty(); req_is_io = 1'b0; cmd_mem_en = 1'b1;
        for (int b = 0; b < 16; b++) begin
            for (int l = 0; l < 16; l++) begin
                mem_base_reg  = {12'((b * 273) % 4096), 4'hF};
                mem_limit_reg = {12'((l * 273) % 4096), 4'h1};
                lo = ((b * 273) % 4096) * 65'h10_0000;
                hi = ((l * 273) % 4096) * 65'h10_0000 + 65'hF_FFFF;
                probe4("R3/R5 mem window", lo, hi, 64'h0);
                req_addr = lo[63:0] | 64'h1_0000_0000;
                check_now("R3 mem above 4GiB");
            end
        end

        // R4: prefetchable window with and without upper words
        all_empty(); req_is_io = 1'b0; cmd_mem_en = 1'b1;
        for (int b = 0; b < 8; b++) begin
            for (int l = 0; l < 8; l++) begin
                logic wide;
                wide = (l != 0);
                pf_base_reg  = {12'(b * 37), wide ? 4'h1 : 4'h0};
                pf_limit_reg = {12'(l * 41 + 5), wide ? 4'h1 : 4'h0};
                pf_base_up   = 32'(b);
                pf_limit_up  = 32'(l);
                lo = b * 37 * 65'h10_0000 + (wide ? b * 65'h1_0000_0000 : 0);
                hi = (l * 41 + 5) * 65'h10_0000 + 65'hF_FFFF + (wide ? l * 65'h1_0000_0000 : 0);
                probe4("R4/R5 prefetch window", lo, hi, 64'h0);
            end
        end

        // R6 R7: enables and space flag against open windows
        all_empty();
        io_base_reg = 8'h00; io_limit_reg = 8'hF0;
        mem_base_reg = 16'h0000; mem_limit_reg = 16'hFFF0;
        pf_base_reg = 16'h0000; pf_limit_reg = 16'hFFF0;
        for (int m = 0; m < 8; m++) begin
            cmd_io_en = m[0]; cmd_mem_en = m[1]; req_is_io = m[2];
            req_addr = 64'h0000_0000_1234_5678;
            check_now("R6/R7 enable and space gating");
        end

        // R8: VGA ranges, boundaries, enables
        all_empty();
        for (int m = 0; m < 8; m++) begin
            logic [31:0] vio [8];
            logic [31:0] vmem [4];
            vio[0] = 32'h3AF; vio[1] = 32'h3B0; vio[2] = 32'h3BB; vio[3] = 32'h3BC;
            vio[4] = 32'h3BF; vio[5] = 32'h3C0; vio[6] = 32'h3DF; vio[7] = 32'h3E0;
            vmem[0] = 32'h9FFFF; vmem[1] = 32'hA0000; vmem[2] = 32'hBFFFF; vmem[3] = 32'hC0000;
            vga_en = m[0]; cmd_io_en = m[1]; cmd_mem_en = m[2];
            req_is_io = 1'b1;
            for (int k = 0; k < 8; k++) begin
                req_addr = {32'h0, vio[k]};
                check_now("R8 vga io range");
            end
            req_is_io = 1'b0;
            for (int k = 0; k < 4; k++) begin
                req_addr = {32'h0, vmem[k]};
                check_now("R8 vga mem range");
            end
            req_addr = 64'h1_000A_0000;
            check_now("R8 vga mem alias above 4GiB");
        end

        // R9: several windows hitting at once
        all_empty(); vga_en = 1'b1; cmd_mem_en = 1'b1; cmd_io_en = 1'b1; req_is_io = 1'b0;
        mem_base_reg = 16'h0000; mem_limit_reg = 16'h0010;
        pf_base_reg = 16'h0000; pf_limit_reg = 16'h0000;
        req_addr = 64'hA8000;
        check_now("R9 multiple hits");

        done = 1'b1;
        finish_run();
    end
endmodule